// File: doc/BRIEF.md
# Phase-Shifted Complementary PWM Generator

The block drives two complementary switch pairs from one shared signed counter. Pair A produces a fixed 50 % square wave and its complement. Pair B has the same period and duty cycle but is delayed by a programmable phase shift. Because the energy passed through a bridge follows the overlap between the two pairs, the shift is the only control quantity. Deadtime is inserted between the high-side and low-side output of each pair, so both switches of a leg are never on together.

The shift value is double-buffered. A new value is written into a staging buffer while the load-ok flag is clear. A strobe then arms the flag, and the staged value becomes active at the next pair-B reload point, which is when the counter equals the pair-B reload value. The transfer clears the flag again. A separate clear strobe withdraws a pending value. Each pair emits a one-cycle reload-event pulse when the counter equals that pair's reload value, so that surrounding logic can be scheduled on the switching edges.

With the defaults, the counter runs from -600 to 599, which is a period of 1200 clocks. The deadtime is 6 clocks. The pair-A reload point is 0, at the pair-A turn-on. The pair-B reload point is -600, at the pair-A turn-off.

Top module: `psc_pwm`

## Requirements
- R1: While run is high, the counter steps by one each clock from CNT_INIT up to CNT_END-1 and then returns to CNT_INIT. The pair-A raw signal is high for counter values of 0 and above, so A repeats every 1200 clocks.
- R2: Within each pair, the high and low outputs are never both high. After every change of the raw signal, both outputs stay low for DEADTIME (6) clocks before the new output rises.
- R3: The pair-B raw signal is high when the counter minus the active shift, wrapped into the counter range, is 0 or above. The rising edge of B_H therefore follows the rising edge of A_H by exactly the active shift, counted in clocks.
- R4: A written shift value above SHIFT_MAX (600) is stored as 600.
- R5: The staged shift becomes active only on a clock where run is high, the counter equals RELOAD_B and load-ok is set. That transfer clears load-ok. Without load-ok, the active shift does not change.
- R6: A shift write presented while load-ok is set is ignored.
- R7: The clear strobe clears load-ok, and it wins over a set strobe presented on the same clock. A clear issued before the reload point cancels the pending transfer.
- R8: evt_a_o is high for exactly the clocks where run is high and the counter equals RELOAD_A (0). evt_b_o is high for exactly the clocks where run is high and the counter equals RELOAD_B (-600). Each is a one-clock pulse, once per period.
- R9: While run is low, all four PWM outputs and both events are low and the counter is held at CNT_INIT. When run rises, both pairs restart from CNT_INIT together, so evt_b_o pulses on the first running clock.
- R10: After reset, the active shift is 0, load-ok is clear and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable for both pairs |
| shift_i | input | SH_W (10) | Phase-shift value to stage |
| shift_wr_i | input | 1 | Write strobe for the staging buffer |
| ldok_set_i | input | 1 | Arms load-ok |
| ldok_clr_i | input | 1 | Clears load-ok |
| a_h_o | output | 1 | Pair A high-side output |
| a_l_o | output | 1 | Pair A low-side output |
| b_h_o | output | 1 | Pair B high-side output |
| b_l_o | output | 1 | Pair B low-side output |
| evt_a_o | output | 1 | Pair A reload-event pulse |
| evt_b_o | output | 1 | Pair B reload-event pulse |

## Verification
The assertions check the following on every cycle:
- the two outputs of a pair are never both high;
- each pair holds a both-low gap of at least the deadtime before an output rises;
- the reload-event pulses last one clock;
- the active shift stays within range and changes only on the clock after a pair-B reload event;
- the outputs are silent after a clock with run low.

The bench's scenarios show the rest:
- the actual phase delay between A_H and B_H for zero, mid-range and saturated shifts;
- the rejection of writes while load-ok is set;
- the cancellation by the clear strobe;
- the absence of any transfer without load-ok;
- the synchronised restart after run is dropped.

// File: rtl/psc_pwm_pkg.sv
package psc_pwm_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } pair_out_t;

  localparam int NUM_PAIRS = 2;
endpackage

// File: rtl/psc_pwm_counter.sv
module psc_pwm_counter #(
  parameter int CNT_W    = 12,
  parameter int CNT_INIT = -600,
  parameter int CNT_LAST = 599
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  output logic signed [CNT_W-1:0] cnt_o
);
  localparam logic signed [CNT_W-1:0] INIT_C = CNT_W'(CNT_INIT);
  localparam logic signed [CNT_W-1:0] LAST_C = CNT_W'(CNT_LAST);

  logic signed [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= INIT_C;
    else if (!run_i)        cnt_q <= INIT_C;
    else if (cnt_q == LAST_C) cnt_q <= INIT_C;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/psc_pwm_shift_buf.sv
module psc_pwm_shift_buf #(
  parameter int CNT_W     = 12,
  parameter int SH_W      = 10,
  parameter int SHIFT_MAX = 600,
  parameter int RELOAD    = -600
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic signed [CNT_W-1:0] cnt_i,
  input  logic [SH_W-1:0]         shift_i,
  input  logic                    wr_i,
  input  logic                    ldok_set_i,
  input  logic                    ldok_clr_i,
  output logic [SH_W-1:0]         shift_act_o
);
  localparam logic [SH_W-1:0]         MAX_C    = SH_W'(SHIFT_MAX);
  localparam logic signed [CNT_W-1:0] RELOAD_C = CNT_W'(RELOAD);

  logic [SH_W-1:0] buf_q, act_q, shift_sat;
  logic            ldok_q, xfer;

  assign shift_sat = (shift_i > MAX_C) ? MAX_C : shift_i;
  // transfer only at the pair-B reload point, a same-cycle clear cancels it
  assign xfer = run_i && (cnt_i == RELOAD_C) && ldok_q && !ldok_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      ldok_q <= 1'b0;
    end else begin
      if (wr_i && !ldok_q) buf_q <= shift_sat;
      if (xfer)            act_q <= buf_q;
      if (ldok_clr_i || xfer) ldok_q <= 1'b0;
      else if (ldok_set_i)    ldok_q <= 1'b1;
    end
  end

  assign shift_act_o = act_q;
endmodule

// File: rtl/psc_pwm_pair.sv
module psc_pwm_pair
  import psc_pwm_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int SH_W     = 10,
  parameter int CNT_INIT = -600,
  parameter int PERIOD   = 1200,
  parameter int DEADTIME = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic signed [CNT_W-1:0] cnt_i,
  input  logic [SH_W-1:0]         shift_i,
  output pair_out_t               out_o
);
  localparam int DT_W = $clog2(DEADTIME + 1);
  localparam int MID  = CNT_INIT + PERIOD / 2;
  localparam logic [DT_W-1:0] DT_C = DT_W'(DEADTIME);

  int          phase;
  logic        raw, raw_q;
  logic [DT_W-1:0] len_q;

  always_comb begin
    phase = int'(cnt_i) - int'(shift_i);
    if (phase < CNT_INIT) phase = phase + PERIOD;
    raw = (phase >= MID);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      len_q <= '0;
    end else if (!run_i) begin
      raw_q <= 1'b0;
      len_q <= '0;
    end else begin
      raw_q <= raw;
      if (raw != raw_q)     len_q <= '0;
      else if (len_q != DT_C) len_q <= len_q + 1'b1;
    end
  end

  assign out_o.hi = run_i &  raw_q & (len_q == DT_C);
  assign out_o.lo = run_i & ~raw_q & (len_q == DT_C);
endmodule

// File: rtl/psc_pwm.sv
module psc_pwm
  import psc_pwm_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int CNT_INIT  = -600,
  parameter int CNT_END   = 600,
  parameter int DEADTIME  = 6,
  parameter int SH_W      = 10,
  parameter int SHIFT_MAX = 600,
  parameter int RELOAD_A  = 0,
  parameter int RELOAD_B  = -600
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [SH_W-1:0] shift_i,
  input  logic            shift_wr_i,
  input  logic            ldok_set_i,
  input  logic            ldok_clr_i,
  output logic            a_h_o,
  output logic            a_l_o,
  output logic            b_h_o,
  output logic            b_l_o,
  output logic            evt_a_o,
  output logic            evt_b_o
);
  localparam int PERIOD = CNT_END - CNT_INIT;
  localparam logic signed [CNT_W-1:0] RA_C = CNT_W'(RELOAD_A);
  localparam logic signed [CNT_W-1:0] RB_C = CNT_W'(RELOAD_B);

  logic signed [CNT_W-1:0] cnt;
  logic [SH_W-1:0]         shift_act;
  pair_out_t               po [NUM_PAIRS];

  psc_pwm_counter #(
    .CNT_W(CNT_W), .CNT_INIT(CNT_INIT), .CNT_LAST(CNT_END - 1)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cnt_o(cnt)
  );

  psc_pwm_shift_buf #(
    .CNT_W(CNT_W), .SH_W(SH_W), .SHIFT_MAX(SHIFT_MAX), .RELOAD(RELOAD_B)
  ) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cnt_i(cnt),
    .shift_i(shift_i), .wr_i(shift_wr_i), .ldok_set_i(ldok_set_i),
    .ldok_clr_i(ldok_clr_i), .shift_act_o(shift_act)
  );

  // pair 0 is the reference, pair 1 is delayed by the active shift
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    psc_pwm_pair #(
      .CNT_W(CNT_W), .SH_W(SH_W), .CNT_INIT(CNT_INIT),
      .PERIOD(PERIOD), .DEADTIME(DEADTIME)
    ) u_pair (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cnt_i(cnt),
      .shift_i((g == 0) ? '0 : shift_act), .out_o(po[g])
    );
  end

  assign a_h_o   = po[0].hi;
  assign a_l_o   = po[0].lo;
  assign b_h_o   = po[1].hi;
  assign b_l_o   = po[1].lo;
  assign evt_a_o = run_i && (cnt == RA_C);
  assign evt_b_o = run_i && (cnt == RB_C);
endmodule

// File: rtl/psc_pwm_chk.sv
module psc_pwm_chk #(
  parameter int DEADTIME  = 6,
  parameter int SH_W      = 10,
  parameter int SHIFT_MAX = 600
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            run_i,
  input logic            a_h_o,
  input logic            a_l_o,
  input logic            b_h_o,
  input logic            b_l_o,
  input logic            evt_a_o,
  input logic            evt_b_o,
  input logic [SH_W-1:0] shift_act
);
  logic [7:0] gap_a_q, gap_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_a_q <= '0;
      gap_b_q <= '0;
    end else begin
      gap_a_q <= (a_h_o || a_l_o) ? 8'd0 : ((gap_a_q == 8'hff) ? gap_a_q : gap_a_q + 8'd1);
      gap_b_q <= (b_h_o || b_l_o) ? 8'd0 : ((gap_b_q == 8'hff) ? gap_b_q : gap_b_q + 8'd1);
    end
  end

  AST_PAIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_h_o && a_l_o) && !(b_h_o && b_l_o)); // R2

  AST_DEADTIME_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(a_h_o) || $rose(a_l_o)) |-> (int'(gap_a_q) >= DEADTIME)); // R2

  AST_DEADTIME_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(b_h_o) || $rose(b_l_o)) |-> (int'(gap_b_q) >= DEADTIME)); // R2

  AST_EVT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_a_o || evt_b_o) |=> !($past(evt_a_o) && evt_a_o) && !($past(evt_b_o) && evt_b_o)); // R8

  AST_SHIFT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(shift_act) <= SHIFT_MAX); // R4

  AST_SHIFT_AT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shift_act) |-> $past(evt_b_o)); // R5

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!run_i |-> !(a_h_o || a_l_o || b_h_o || b_l_o || evt_a_o || evt_b_o))); // R9
endmodule

bind psc_pwm psc_pwm_chk #(
  .DEADTIME(DEADTIME), .SH_W(SH_W), .SHIFT_MAX(SHIFT_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
  .a_h_o(a_h_o), .a_l_o(a_l_o), .b_h_o(b_h_o), .b_l_o(b_l_o),
  .evt_a_o(evt_a_o), .evt_b_o(evt_b_o), .shift_act(shift_act)
);

// File: tb/tb_psc_pwm.sv
module tb_psc_pwm;
  localparam int DT  = 6;
  localparam int PER = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [9:0] shift = '0;
  logic wr = 1'b0, lset = 1'b0, lclr = 1'b0;
  logic a_h, a_l, b_h, b_l, ev_a, ev_b;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  psc_pwm dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .shift_i(shift),
    .shift_wr_i(wr), .ldok_set_i(lset), .ldok_clr_i(lclr),
    .a_h_o(a_h), .a_l_o(a_l), .b_h_o(b_h), .b_l_o(b_l),
    .evt_a_o(ev_a), .evt_b_o(ev_b)
  );

  // reference model
  int m_cnt = -600, m_act = 0, m_buf = 0, m_la = 0, m_lb = 0;
  bit m_ldok = 0, m_ra = 0, m_rb = 0;

  function automatic bit raw_of(int c, int s);
    int p = c - s;
    if (p < -600) p += PER;
    return p >= 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = -600; m_act = 0; m_buf = 0; m_ldok = 0;
      m_ra = 0; m_rb = 0; m_la = 0; m_lb = 0;
    end else begin
      bit na, nb, xfer;
      int sv;
      na = raw_of(m_cnt, 0);
      nb = raw_of(m_cnt, m_act);
      xfer = run && m_cnt == -600 && m_ldok && !lclr;
      sv = (shift > 600) ? 600 : int'(shift);
      if (wr && !m_ldok) m_buf = sv;
      if (xfer) m_act = m_buf;
      if (lclr || xfer) m_ldok = 0; else if (lset) m_ldok = 1;
      if (!run) begin
        m_cnt = -600; m_ra = 0; m_rb = 0; m_la = 0; m_lb = 0;
      end else begin
        m_la = (na != m_ra) ? 0 : ((m_la < DT) ? m_la + 1 : DT);
        m_lb = (nb != m_rb) ? 0 : ((m_lb < DT) ? m_lb + 1 : DT);
        m_ra = na; m_rb = nb;
        m_cnt = (m_cnt == 599) ? -600 : m_cnt + 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1", int'(a_h), int'(run && m_ra && m_la == DT), "a_h");
      chk("R2", int'(a_l), int'(run && !m_ra && m_la == DT), "a_l");
      chk("R3", int'(b_h), int'(run && m_rb && m_lb == DT), "b_h");
      chk("R3", int'(b_l), int'(run && !m_rb && m_lb == DT), "b_l");
      chk("R8", int'(ev_a), int'(run && m_cnt == 0), "evt_a");
      chk("R8", int'(ev_b), int'(run && m_cnt == -600), "evt_b");
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_shift(int v, bit arm);
    tick(1); shift = 10'(v); wr = 1'b1;
    tick(1); wr = 1'b0;
    if (arm) begin lset = 1'b1; tick(1); lset = 1'b0; end
  endtask

  // cycles from an A_H rising edge to the next B_H rising edge
  task automatic meas_delay(output int d);
    logic pa, pb;
    @(negedge clk); pa = a_h; pb = b_h;
    forever begin
      @(negedge clk);
      if (a_h && !pa) break;
      pa = a_h; pb = b_h;
    end
    d = 0;
    while (!(b_h && !pb)) begin
      pb = b_h;
      @(negedge clk);
      d++;
    end
  endtask

  task automatic meas_period(output int d);
    logic pa;
    @(negedge clk); pa = a_h;
    forever begin @(negedge clk); if (a_h && !pa) break; pa = a_h; end
    d = 0; pa = a_h;
    forever begin @(negedge clk); d++; if (a_h && !pa) break; pa = a_h; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d, na, nb;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R10", int'({a_h, a_l, b_h, b_l, ev_a, ev_b}), 0, "outputs after reset");

    run = 1'b1;
    tick(2 * PER);
    meas_delay(d);   chk("R10", d, 0, "initial shift delay");
    meas_period(d);  chk("R1", d, PER, "A_H period");

    write_shift(300, 1);
    tick(2 * PER + 10);
    meas_delay(d);   chk("R5", d, 300, "delay after load");

    write_shift(1000, 1);
    tick(2 * PER + 10);
    meas_delay(d);   chk("R4", d, 600, "saturated delay");

    write_shift(200, 1);
    write_shift(450, 0);
    tick(2 * PER + 10);
    meas_delay(d);   chk("R6", d, 200, "write while armed ignored");

    write_shift(100, 1);
    lclr = 1'b1; tick(1); lclr = 1'b0;
    tick(2 * PER + 10);
    meas_delay(d);   chk("R7", d, 200, "clear cancels transfer");

    lset = 1'b1; lclr = 1'b1; tick(1); lset = 1'b0; lclr = 1'b0;
    tick(2 * PER + 10);
    meas_delay(d);   chk("R7", d, 200, "clear beats set");

    write_shift(50, 0);
    tick(2 * PER + 10);
    meas_delay(d);   chk("R5", d, 200, "no transfer without load-ok");
    lset = 1'b1; tick(1); lset = 1'b0;
    tick(2 * PER + 10);
    meas_delay(d);   chk("R5", d, 50, "pending value applied");

    na = 0; nb = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      na += int'(ev_a); nb += int'(ev_b);
    end
    chk("R8", na, 1, "evt_a per period");
    chk("R8", nb, 1, "evt_b per period");

    tick(1); run = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9", int'({a_h, a_l, b_h, b_l, ev_a, ev_b}), 0, "idle outputs");
    end
    tick(1); run = 1'b1;
    @(negedge clk);
    chk("R9", int'(ev_b), 1, "restart at initial count");
    tick(2 * PER);
    meas_delay(d);   chk("R9", d, 50, "shift kept over restart");

    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule